// File: doc/BRIEF.md
# Keyed-Write Fault Register Bank

This block is the register file of a safety fault management unit, reached through a 32-bit APB-style slave port with no wait states. It holds a small set of per-record error registers (feature, control and status, each 64 bits wide), a group status summary, ping control and ping mask registers, a unit status word, and write-only command registers. Every 64-bit register is seen on the bus as two 32-bit words that are read and written one at a time.

Each write is guarded by a one-shot unlock key. Software must write the key word directly before every protected write, and each key covers exactly one write. Some writes are commands: they occupy the unit for a fixed number of cycles, and a ready bit in the status word shows when the next command may be issued. One command clears individual entries of an internal enable array of safety mechanisms, which is addressed by a block identifier and a mechanism index and is visible on an output vector. Reads never need the key. Ping control and ping mask are plain storage. The block has no data stream, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `fmu_regbank`

## Requirements
- R1: After reset the ready bit is 1. All control, status, ping control and ping mask words read 0. Every bit of `mech_en` is 1.
- R2: A write to any register other than the key (address 0x858) takes effect only when the access just before it wrote exactly 0x000000BE to the key. That write uses up the key, so a second write straight after it is ignored.
- R3: A protected write without an armed key leaves its register unchanged. Any access in between, read or write, disarms the key, and so does a key write of any value other than 0x000000BE.
- R4: Record n occupies addresses n*0x40 + offset, for n below N_REC. The offsets are 0x00/0x04 for feature LO/HI (reading FEAT_WORD and n), 0x08/0x0C for control LO/HI and 0x10/0x14 for status LO/HI. Each word is written and read separately. All offsets of records at or above N_REC read 0.
- R5: Bit 0 of the status word (0x850) is 1 when the unit is idle. An accepted command write clears it for exactly BUSY_CYC clock cycles. The command registers are record status LO/HI, ping-now (0x844), mechanism clear (0x860) and inject (0x864).
- R6: A keyed command write made while ready is 0 is dropped. It changes no register, does not restart the busy period, and still uses up the key.
- R7: An inject command with record index v in bits [7:0] sets bit 30 of record v's status LO word. Indices at or above N_REC are ignored. Status words clear the bits written as 1 and keep the rest. Bit n of group status LO (0x800) is 1 exactly when record n has a nonzero status word.
- R8: A mechanism clear command carries the block ID in bits [15:8] and the mechanism index in bits [7:0]. The block IDs are 0 distributor, 1 SPI collator, 2 wake request, 3..10 ITS instances, 11..42 PPI blocks, with 4, 2, 2, 3 and 2 mechanisms per block by default. The command clears `mech_en` bit base(b)+m, where base(b) is the sum of the mechanism counts of all blocks below b. An unknown block or an out-of-range index changes nothing.
- R9: The write-only words (key, ping-now, mechanism clear, inject) and group status HI read 0. The read-only words (feature, group status, unit status, record count at 0x854 = N_REC) ignore keyed writes. Ping control (0x840) and ping mask LO/HI (0x848/0x84C) hold keyed writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase; a transfer completes on the edge where psel and penable are both 1 |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is 1 and pwrite is 0 |
| mech_en | output | MECH_W | Safety mechanism enable array, one bit per mechanism |

## Verification
The key gate is driven with five patterns: a correct key, a missing key, a wrong key value, a key followed by an unrelated read, and two writes in a row after one key. Together these separate a gate that checks the value from one that only checks the address, and a one-shot key from a sticky one. The busy period is sampled one cycle before and at the cycle where ready should return, which exposes off-by-one counters. A command is also issued during the busy period, to tell a dropped command from one that restarts the timer. A sweep over every block ID from 0 to 44 and every mechanism index from 0 to 5 is compared against a position computed from the per-block counts. It shows whether the block boundaries are in the right place and whether indices just past a block's count are rejected rather than spilling into the next block.

// File: rtl/fmu_pkg.sv
package fmu_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0000_00BE;

  // fixed register addresses outside the record region
  localparam logic [ADDR_W-1:0] A_GRP_LO  = 12'h800;
  localparam logic [ADDR_W-1:0] A_GRP_HI  = 12'h804;
  localparam logic [ADDR_W-1:0] A_PCTL    = 12'h840;
  localparam logic [ADDR_W-1:0] A_PNOW    = 12'h844;
  localparam logic [ADDR_W-1:0] A_PMSK_LO = 12'h848;
  localparam logic [ADDR_W-1:0] A_PMSK_HI = 12'h84C;
  localparam logic [ADDR_W-1:0] A_STAT    = 12'h850;
  localparam logic [ADDR_W-1:0] A_NREC    = 12'h854;
  localparam logic [ADDR_W-1:0] A_KEY     = 12'h858;
  localparam logic [ADDR_W-1:0] A_MCLR    = 12'h860;
  localparam logic [ADDR_W-1:0] A_INJ     = 12'h864;

  // word offsets inside one 64-byte record
  localparam logic [5:0] O_FEAT_LO = 6'h00;
  localparam logic [5:0] O_FEAT_HI = 6'h04;
  localparam logic [5:0] O_CTL_LO  = 6'h08;
  localparam logic [5:0] O_CTL_HI  = 6'h0C;
  localparam logic [5:0] O_ST_LO   = 6'h10;
  localparam logic [5:0] O_ST_HI   = 6'h14;

  localparam int INJ_BIT = 30;

  // block identifier layout
  localparam int BLK_DIST  = 0;
  localparam int BLK_COL   = 1;
  localparam int BLK_WAKE  = 2;
  localparam int BLK_ITS0  = 3;
  localparam int N_ITS     = 8;
  localparam int BLK_PPI0  = BLK_ITS0 + N_ITS;
  localparam int N_PPI     = 32;
  localparam int N_BLK     = BLK_PPI0 + N_PPI;

  function automatic int blk_count(input int b, input int nd, input int nc,
                                   input int nw, input int ni, input int np);
    if (b == BLK_DIST)           return nd;
    else if (b == BLK_COL)       return nc;
    else if (b == BLK_WAKE)      return nw;
    else if (b < BLK_PPI0)       return ni;
    else if (b < N_BLK)          return np;
    else                         return 0;
  endfunction

  function automatic int blk_base(input int b, input int nd, input int nc,
                                  input int nw, input int ni, input int np);
    int acc;
    acc = 0;
    for (int k = 0; k < b; k++) acc += blk_count(k, nd, nc, nw, ni, np);
    return acc;
  endfunction
endpackage

// File: rtl/fmu_key_gate.sv
module fmu_key_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic key_load,
  output logic armed
);
  logic armed_q;

  // any completed transfer re-evaluates the key: only a good key write arms it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (acc) armed_q <= key_load;
  end

  assign armed = armed_q;
endmodule

// File: rtl/fmu_busy_timer.sv
module fmu_busy_timer #(
  parameter int BUSY_CYC = 8,
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/fmu_mech_array.sv
module fmu_mech_array
  import fmu_pkg::*;
#(
  parameter int SM_DIST = 4,
  parameter int SM_COL  = 2,
  parameter int SM_WAKE = 2,
  parameter int SM_ITS  = 3,
  parameter int SM_PPI  = 2,
  localparam int MW = SM_DIST + SM_COL + SM_WAKE + N_ITS*SM_ITS + N_PPI*SM_PPI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [7:0]    blk_id,
  input  logic [7:0]    mech_id,
  output logic [MW-1:0] en
);
  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    localparam int BASE = blk_base(b, SM_DIST, SM_COL, SM_WAKE, SM_ITS, SM_PPI);
    localparam int CNT  = blk_count(b, SM_DIST, SM_COL, SM_WAKE, SM_ITS, SM_PPI);
    logic blk_hit;
    assign blk_hit = clr && (blk_id == 8'(b));
    for (genvar m = 0; m < CNT; m++) begin : g_mech
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             bit_q <= 1'b1;
        else if (blk_hit && mech_id == 8'(m))   bit_q <= 1'b0;
      end
      assign en[BASE+m] = bit_q;
    end
  end
endmodule

// File: rtl/fmu_regbank.sv
module fmu_regbank
  import fmu_pkg::*;
#(
  parameter int          N_REC     = 2,
  parameter int          BUSY_CYC  = 8,
  parameter logic [31:0] FEAT_WORD = 32'h0000_0A41,
  parameter int          SM_DIST   = 4,
  parameter int          SM_COL    = 2,
  parameter int          SM_WAKE   = 2,
  parameter int          SM_ITS    = 3,
  parameter int          SM_PPI    = 2,
  localparam int MECH_W = SM_DIST + SM_COL + SM_WAKE + N_ITS*SM_ITS + N_PPI*SM_PPI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [MECH_W-1:0] mech_en
);
  localparam logic [5:0] NREC6 = 6'(N_REC);

  // ---------------- decode ----------------
  logic       acc, wr;
  logic       in_rec, rec_ok, is_key, is_st_off, is_cmd;
  logic [4:0] rec_idx;
  logic [5:0] rec_off;

  assign acc       = psel & penable;
  assign wr        = acc & pwrite;
  assign in_rec    = ~paddr[11];
  assign rec_idx   = paddr[10:6];
  assign rec_off   = paddr[5:0];
  assign rec_ok    = in_rec && ({1'b0, rec_idx} < NREC6);
  assign is_key    = (paddr == A_KEY);
  assign is_st_off = (rec_off == O_ST_LO) || (rec_off == O_ST_HI);
  assign is_cmd    = (rec_ok && is_st_off) || (paddr == A_PNOW) ||
                     (paddr == A_MCLR) || (paddr == A_INJ);

  // ---------------- key and busy ----------------
  logic key_armed, ready;
  logic prot, cmd_ok, plain_ok;

  fmu_key_gate u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .key_load (wr && is_key && (pwdata == UNLOCK_WORD)),
    .armed    (key_armed)
  );

  assign prot     = wr && key_armed && !is_key;
  assign cmd_ok   = prot && is_cmd && ready;
  assign plain_ok = prot && !is_cmd;

  fmu_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cmd_ok),
    .ready (ready)
  );

  // ---------------- mechanism enables ----------------
  fmu_mech_array #(
    .SM_DIST(SM_DIST), .SM_COL(SM_COL), .SM_WAKE(SM_WAKE),
    .SM_ITS(SM_ITS), .SM_PPI(SM_PPI)
  ) u_mech (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cmd_ok && (paddr == A_MCLR)),
    .blk_id  (pwdata[15:8]),
    .mech_id (pwdata[7:0]),
    .en      (mech_en)
  );

  // ---------------- error records ----------------
  logic [31:0]      rec_rd [N_REC];
  logic [N_REC-1:0] rec_flag;

  for (genvar r = 0; r < N_REC; r++) begin : g_rec
    logic [31:0] ctl_lo, ctl_hi, st_lo, st_hi, rd_w;
    logic        hit, inj_hit;

    assign hit     = rec_ok && (rec_idx == 5'(r));
    assign inj_hit = cmd_ok && (paddr == A_INJ) && (pwdata[7:0] == 8'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_lo <= '0;
        ctl_hi <= '0;
      end else if (plain_ok && hit) begin
        if (rec_off == O_CTL_LO) ctl_lo <= pwdata;
        if (rec_off == O_CTL_HI) ctl_hi <= pwdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_lo <= '0;
        st_hi <= '0;
      end else begin
        if (cmd_ok && hit && rec_off == O_ST_LO) st_lo <= st_lo & ~pwdata;
        else if (inj_hit)                        st_lo[INJ_BIT] <= 1'b1;
        if (cmd_ok && hit && rec_off == O_ST_HI) st_hi <= st_hi & ~pwdata;
      end
    end

    always_comb begin
      case (rec_off)
        O_FEAT_LO: rd_w = FEAT_WORD;
        O_FEAT_HI: rd_w = 32'(r);
        O_CTL_LO:  rd_w = ctl_lo;
        O_CTL_HI:  rd_w = ctl_hi;
        O_ST_LO:   rd_w = st_lo;
        O_ST_HI:   rd_w = st_hi;
        default:   rd_w = '0;
      endcase
    end

    assign rec_rd[r]   = rd_w;
    assign rec_flag[r] = |{st_hi, st_lo};
  end

  // ---------------- ping registers ----------------
  logic [31:0] ping_ctl, pmsk_lo, pmsk_hi, grp_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ping_ctl <= '0;
      pmsk_lo  <= '0;
      pmsk_hi  <= '0;
    end else if (plain_ok) begin
      if (paddr == A_PCTL)    ping_ctl <= pwdata;
      if (paddr == A_PMSK_LO) pmsk_lo  <= pwdata;
      if (paddr == A_PMSK_HI) pmsk_hi  <= pwdata;
    end
  end

  always_comb begin
    grp_lo = '0;
    for (int r = 0; r < N_REC; r++) grp_lo[r] = rec_flag[r];
  end

  // ---------------- read mux ----------------
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (in_rec) begin
        for (int r = 0; r < N_REC; r++)
          if (rec_ok && rec_idx == 5'(r)) prdata = rec_rd[r];
      end else begin
        case (paddr)
          A_GRP_LO:  prdata = grp_lo;
          A_PCTL:    prdata = ping_ctl;
          A_PMSK_LO: prdata = pmsk_lo;
          A_PMSK_HI: prdata = pmsk_hi;
          A_STAT:    prdata = {31'b0, ready};
          A_NREC:    prdata = 32'(N_REC);
          default:   prdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/fmu_regbank_chk.sv
module fmu_regbank_chk
  import fmu_pkg::*;
#(
  parameter int MW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [11:0]   paddr,
  input logic [31:0]   pwdata,
  input logic [31:0]   prdata,
  input logic [MW-1:0] mech_en,
  input logic          key_armed,
  input logic          ready,
  input logic          cmd_ok
);
  logic good_key;
  assign good_key = psel && penable && pwrite && paddr == A_KEY && pwdata == UNLOCK_WORD;

  // R2: any transfer that is not a good key write leaves the key disarmed
  a_r2_key_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !good_key) |=> !key_armed);

  // R3: a good key write arms the gate for the next transfer
  a_r3_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    good_key |=> key_armed);

  // R5: an accepted command drops ready on the next cycle
  a_r5_cmd_busies: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> !ready);

  // R5: idle stays idle without an accepted command
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !cmd_ok) |=> ready);

  // R8: enable bits only ever fall
  a_r8_en_only_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (mech_en & ~$past(mech_en)) == '0);

  // R9: write-only words read back as zero
  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (paddr == A_KEY || paddr == A_PNOW ||
                         paddr == A_MCLR || paddr == A_INJ)) |-> prdata == '0);
endmodule

bind fmu_regbank fmu_regbank_chk #(.MW(MECH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .mech_en   (mech_en),
  .key_armed (key_armed),
  .ready     (ready),
  .cmd_ok    (cmd_ok)
);

// File: tb/tb_fmu_regbank.sv
`timescale 1ns/1ps
module tb_fmu_regbank;
  localparam int NREC = 2;
  localparam int BUSY = 8;
  localparam int MW   = 96;
  localparam logic [31:0] FEAT = 32'h0000_0A41;
  localparam logic [31:0] KEYV = 32'h0000_00BE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [MW-1:0] mech_en;
  logic [MW-1:0] exp_en;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  fmu_regbank dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .mech_en(mech_en)
  );

  task automatic chk(input string tag, input logic [MW-1:0] got, input logic [MW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1; d = prdata;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  task automatic keyed_wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr(12'h858, KEYV);
    bus_wr(a, d);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] e);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, MW'(d), MW'(e));
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int cnt_of(input int b);
    if (b == 0) return 4;
    if (b == 1 || b == 2) return 2;
    if (b >= 3 && b <= 10) return 3;
    if (b >= 11 && b <= 42) return 2;
    return 0;
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got no completion, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_en = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 ready", 12'h850, 32'h1);
    rd_chk("R1 ctl", 12'h008, 32'h0);
    rd_chk("R1 st", 12'h050, 32'h0);
    rd_chk("R1 pctl", 12'h840, 32'h0);
    rd_chk("R1 pmask", 12'h84C, 32'h0);
    @(negedge clk); chk("R1 mech_en", mech_en, exp_en);

    // R4 record layout sweep, including unused records
    for (int r = 0; r < NREC + 2; r++) begin
      logic [11:0] b;
      logic [31:0] pat;
      b = 12'(r * 64);
      pat = 32'hA5C3_0000 ^ (32'(r) << 8);
      keyed_wr(b + 12'h08, pat);
      keyed_wr(b + 12'h0C, ~pat);
      if (r < NREC) begin
        rd_chk("R4 ctl lo", b + 12'h08, pat);
        rd_chk("R4 ctl hi", b + 12'h0C, ~pat);
        rd_chk("R4 feat lo", b + 12'h00, FEAT);
        rd_chk("R4 feat hi", b + 12'h04, 32'(r));
      end else begin
        for (int o = 0; o < 6; o++) rd_chk("R4 unused rec", b + 12'(o * 4), 32'h0);
      end
    end
    rd_chk("R4 rec0 untouched by rec1", 12'h008, 32'hA5C3_0000);
    rd_chk("R4 unused record 31", 12'h7C8, 32'h0);

    // R2 one key, one write
    keyed_wr(12'h840, 32'h11);
    bus_wr(12'h840, 32'h22);
    rd_chk("R2 key consumed", 12'h840, 32'h11);
    keyed_wr(12'h848, 32'h1234_5678);
    keyed_wr(12'h84C, 32'h9ABC_DEF0);
    rd_chk("R2 mask lo", 12'h848, 32'h1234_5678);
    rd_chk("R2 mask hi", 12'h84C, 32'h9ABC_DEF0);

    // R3 missing, wrong and interrupted keys
    bus_wr(12'h840, 32'h33);
    rd_chk("R3 no key", 12'h840, 32'h11);
    bus_wr(12'h858, 32'h0000_00BF); bus_wr(12'h840, 32'h44);
    rd_chk("R3 wrong key", 12'h840, 32'h11);
    bus_wr(12'h858, 32'h0000_01BE); bus_wr(12'h840, 32'h45);
    rd_chk("R3 upper bits in key", 12'h840, 32'h11);
    bus_wr(12'h858, KEYV); bus_rd(12'h850, v); bus_wr(12'h840, 32'h55);
    rd_chk("R3 read between", 12'h840, 32'h11);
    bus_wr(12'h858, KEYV); bus_wr(12'h858, 32'h0); bus_wr(12'h840, 32'h66);
    rd_chk("R3 key overwritten", 12'h840, 32'h11);
    bus_wr(12'h858, KEYV); bus_wr(12'h858, KEYV); bus_wr(12'h840, 32'h77);
    rd_chk("R3 rearmed key", 12'h840, 32'h77);

    // R5 busy window
    bus_wr(12'h844, 32'h1);
    rd_chk("R5 unkeyed cmd no busy", 12'h850, 32'h1);
    keyed_wr(12'h844, 32'h1);
    rd_chk("R5 busy at once", 12'h850, 32'h0);
    idle(BUSY);
    keyed_wr(12'h844, 32'h1); idle(BUSY - 2);
    rd_chk("R5 busy last cycle", 12'h850, 32'h0);
    idle(BUSY);
    keyed_wr(12'h844, 32'h1); idle(BUSY - 1);
    rd_chk("R5 ready after BUSY_CYC", 12'h850, 32'h1);

    // R6 command while busy is dropped without restarting the timer
    keyed_wr(12'h860, 32'h0000_0000);
    keyed_wr(12'h860, 32'h0000_0001);
    exp_en[0] = 1'b0;
    idle(BUSY - 5);
    rd_chk("R6 timer not restarted", 12'h850, 32'h1);
    @(negedge clk); chk("R6 dropped clear", mech_en, exp_en);
    bus_wr(12'h840, 32'h88);
    rd_chk("R6 key still consumed", 12'h840, 32'h77);

    // R7 inject, group status, write-one-to-clear
    keyed_wr(12'h864, 32'h1); idle(BUSY);
    rd_chk("R7 inject rec1", 12'h050, 32'h4000_0000);
    rd_chk("R7 rec0 clean", 12'h010, 32'h0);
    rd_chk("R7 group", 12'h800, 32'h2);
    keyed_wr(12'h864, 32'h5); idle(BUSY);
    rd_chk("R7 inject out of range", 12'h800, 32'h2);
    keyed_wr(12'h050, 32'h0000_0001); idle(BUSY);
    rd_chk("R7 clear other bit", 12'h050, 32'h4000_0000);
    bus_wr(12'h050, 32'h4000_0000);
    rd_chk("R7 unkeyed clear ignored", 12'h050, 32'h4000_0000);
    keyed_wr(12'h050, 32'h4000_0000); idle(BUSY);
    rd_chk("R7 cleared", 12'h050, 32'h0);
    rd_chk("R7 group empty", 12'h800, 32'h0);
    keyed_wr(12'h864, 32'h0); idle(BUSY);
    rd_chk("R7 group rec0", 12'h800, 32'h1);

    // R8 mechanism clear sweep
    for (int b = 0; b < 45; b++) begin
      for (int m = 0; m < 6; m++) begin
        int base;
        base = 0;
        for (int k = 0; k < b; k++) base += cnt_of(k);
        keyed_wr(12'h860, {16'h0, 8'(b), 8'(m)});
        idle(BUSY);
        if (m < cnt_of(b)) exp_en[base + m] = 1'b0;
        @(negedge clk); chk($sformatf("R8 blk %0d mech %0d", b, m), mech_en, exp_en);
      end
    end
    keyed_wr(12'h860, 32'h0000_FF00); idle(BUSY);
    @(negedge clk); chk("R8 block 255", mech_en, exp_en);

    // R9 write-only and read-only words
    rd_chk("R9 key reads 0", 12'h858, 32'h0);
    rd_chk("R9 pnow reads 0", 12'h844, 32'h0);
    rd_chk("R9 mclr reads 0", 12'h860, 32'h0);
    rd_chk("R9 inj reads 0", 12'h864, 32'h0);
    rd_chk("R9 grp hi reads 0", 12'h804, 32'h0);
    keyed_wr(12'h854, 32'hFF);
    rd_chk("R9 nrec", 12'h854, 32'(NREC));
    keyed_wr(12'h000, 32'hDEAD);
    rd_chk("R9 feat ro", 12'h000, FEAT);
    keyed_wr(12'h850, 32'h0);
    rd_chk("R9 stat ro", 12'h850, 32'h1);
    keyed_wr(12'h800, 32'h0);
    rd_chk("R9 grp ro", 12'h800, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule